// File: doc/BRIEF.md
# Battery-Domain Real-Time Counter

This block keeps time in a slow, always-on clock domain and exposes it to a fast bus-side register port. A 47-bit counter advances on each edge of a 32768 Hz slow clock. Its value is a 32.15 fixed-point number of seconds: the upper 32 bits count whole seconds and the lower 15 bits hold the fraction. Software sees the counter as two 32-bit words. A control word holds a run request and a trim setting.

The run request, the trim setting and the counter-load requests cross into the slow domain through two-flop synchronizers. The slow-domain run state and the counter value come back to the bus domain through two-flop synchronizers as well. As a result, the run bit that software reads back lags its write by a known number of slow edges plus two bus clocks. Software sets the counter while it is stopped, sets the run bit, and polls the readback until it matches. The two counter words are not captured together, so software reads the pair twice until two reads agree.

Top module: `bkp_rtc`

## Requirements
- R1: After both resets, the control word, the high counter word and the low counter word all read 0.
- R2: The control word is at offset 0x38. Bit 0 reads back the slow-domain run state. Bit 8 is the trim enable. Bits 14:10 are the 5-bit trim value. Bits 8 and 14:10 read back as written, and every other bit reads 0.
- R3: Read data appears on `bus_rdata` one bus clock after the read request. Any offset other than 0x38, 0x50 and 0x54 reads 0.
- R4: After bit 0 of the control word is written, the readback keeps its old value through the first two slow edges. The slow-domain run state takes the new value on the third slow edge, and the readback shows it within two bus clocks after that.
- R5: Once the slow-domain run state is 1, the next two slow edges leave the count unchanged. Every slow edge after those two adds one to the count.
- R6: The word at 0x50 returns count bits 46:32 in its bits 14:0 and reads 0 above them. The word at 0x54 returns count bits 31:0. A carry out of bit 31 reaches bit 32.
- R7: While the run readback is 0, a write to 0x50 or 0x54 replaces that half of the count. The new value takes effect on the third slow edge after the write.
- R8: While the run readback is 1, writes to 0x50 and 0x54 are ignored, both at once and on any later slow edge.
- R9: After bit 0 is cleared, the count keeps advancing up to and including the third slow edge. From then on it holds its value.
- R10: When trim is enabled, a counting edge on which the fraction is 0x7FFF adds the trim value as a signed two's-complement number on top of the usual +1. When trim is disabled, no adjustment is made.
- R11: The count wraps from all ones to zero modulo 2^47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | 32768 Hz timekeeping clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
The bench drives the slow clock itself, one edge at a time, while the bus clock runs freely. This makes every slow-domain result land on a known slow edge.

Counter loads and run-state changes take effect on the third slow edge after their write. The count is first affected on the sixth slow edge after a run request, and the run readback follows its slow edge by at most two bus clocks. Read data follows its request by one bus clock.

After every slow edge, the bench waits four bus clocks before it reads. It checks the run readback both one edge before and on the edge where it is due to change. Every expected count is built by stepping a model of R5, R10 and R11 through the exact number of counting edges.

// File: rtl/bkp_rtc_pkg.sv
package bkp_rtc_pkg;

    localparam int CNT_W     = 47;
    localparam int FRAC_W    = 15;
    localparam int WORD_W    = 32;
    localparam int HI_W      = CNT_W - WORD_W;
    localparam int CAL_W     = 5;
    localparam int ADDR_W    = 8;
    localparam int START_DLY = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h54;

    localparam int CTL_RUN_BIT   = 0;
    localparam int CTL_TRIMEN_BIT = 8;
    localparam int CTL_TRIM_LSB  = 10;

    typedef struct packed {
        logic             trim_en;
        logic [CAL_W-1:0] trim_val;
    } trim_cfg_t;

    // request bundle handed from bus domain to slow domain
    typedef struct packed {
        logic      run;
        trim_cfg_t trim;
        logic      ld_hi;
        logic      ld_lo;
    } xreq_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_HI,
        SEL_LO
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == OFS_CTRL)        s = SEL_CTRL;
        else if (a == OFS_CNT_HI) s = SEL_HI;
        else if (a == OFS_CNT_LO) s = SEL_LO;
        else                      s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [CNT_W-1:0] trim_extend(input logic [CAL_W-1:0] v);
        return {{(CNT_W-CAL_W){v[CAL_W-1]}}, v};
    endfunction

endpackage

// File: rtl/bkp_rtc_sync.sv
module bkp_rtc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];

endmodule

// File: rtl/bkp_rtc_regs.sv
module bkp_rtc_regs
    import bkp_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              run_rb,
    input  logic [CNT_W-1:0]  cnt_bus,
    output logic              run_req,
    output trim_cfg_t         trim_cfg,
    output logic [HI_W-1:0]   preset_hi,
    output logic [WORD_W-1:0] preset_lo,
    output logic              ld_hi_tog,
    output logic              ld_lo_tog
);

    reg_sel_e          sel;
    logic [WORD_W-1:0] rd_word;
    logic              wr_cyc;
    logic              rd_cyc;

    assign sel    = decode_addr(bus_addr);
    assign wr_cyc = bus_en && bus_we;
    assign rd_cyc = bus_en && !bus_we;

    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_CTRL: begin
                rd_word[CTL_RUN_BIT]               = run_rb;
                rd_word[CTL_TRIMEN_BIT]            = trim_cfg.trim_en;
                rd_word[CTL_TRIM_LSB +: CAL_W]     = trim_cfg.trim_val;
            end
            SEL_HI:  rd_word[HI_W-1:0] = cnt_bus[CNT_W-1:WORD_W];
            SEL_LO:  rd_word = cnt_bus[WORD_W-1:0];
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_req   <= 1'b0;
            trim_cfg  <= '0;
            preset_hi <= '0;
            preset_lo <= '0;
            ld_hi_tog <= 1'b0;
            ld_lo_tog <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (wr_cyc) begin
                case (sel)
                    SEL_CTRL: begin
                        run_req           <= bus_wdata[CTL_RUN_BIT];
                        trim_cfg.trim_en  <= bus_wdata[CTL_TRIMEN_BIT];
                        trim_cfg.trim_val <= bus_wdata[CTL_TRIM_LSB +: CAL_W];
                    end
                    SEL_HI: if (!run_rb) begin
                        preset_hi <= bus_wdata[HI_W-1:0];
                        ld_hi_tog <= ~ld_hi_tog;
                    end
                    SEL_LO: if (!run_rb) begin
                        preset_lo <= bus_wdata;
                        ld_lo_tog <= ~ld_lo_tog;
                    end
                    default: ;
                endcase
            end
            if (rd_cyc) bus_rdata <= rd_word;
        end
    end

    AST_RUN_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_cyc && run_rb && (sel == SEL_HI || sel == SEL_LO)) |=>
        ($stable(preset_hi) && $stable(preset_lo) && $stable(ld_hi_tog) && $stable(ld_lo_tog))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_cyc && sel == SEL_NONE) |=> (bus_rdata == '0)); // R3

    AST_CTRL_RUN_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (rd_cyc && sel == SEL_CTRL) |=> (bus_rdata[CTL_RUN_BIT] == $past(run_rb))); // R2

endmodule

// File: rtl/bkp_rtc_core.sv
module bkp_rtc_core
    import bkp_rtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              slow_clk,
    input  logic              slow_rst,
    input  xreq_t             req_async,
    input  logic [HI_W-1:0]   preset_hi,
    input  logic [WORD_W-1:0] preset_lo,
    output logic [CNT_W-1:0]  cnt,
    output logic              run_state
);

    localparam int WARM_W = $clog2(START_DLY + 1);
    localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(START_DLY);
    localparam logic [CNT_W-1:0]  ONE = CNT_W'(1);

    xreq_t             rq;
    logic              ld_hi_prev;
    logic              ld_lo_prev;
    logic              load_hi;
    logic              load_lo;
    logic              ld_any;
    logic [WARM_W-1:0] warm;
    logic              counting;
    logic              frac_full;
    logic [CNT_W-1:0]  adj;
    logic [CNT_W-1:0]  cnt_step;

    bkp_rtc_sync #(.W($bits(xreq_t)), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk (slow_clk),
        .rst (slow_rst),
        .d   (req_async),
        .q   (rq)
    );

    assign load_hi   = rq.ld_hi != ld_hi_prev;
    assign load_lo   = rq.ld_lo != ld_lo_prev;
    assign ld_any    = load_hi || load_lo;
    assign counting  = run_state && (warm == WARM_DONE);
    assign frac_full = &cnt[FRAC_W-1:0];

    always_comb begin
        adj = '0;
        if (rq.trim.trim_en && frac_full) adj = trim_extend(rq.trim.trim_val);
        cnt_step = cnt + ONE + adj;
    end

    always_ff @(posedge slow_clk) begin
        if (slow_rst) begin
            run_state  <= 1'b0;
            warm       <= '0;
            ld_hi_prev <= 1'b0;
            ld_lo_prev <= 1'b0;
            cnt        <= '0;
        end else begin
            run_state  <= rq.run;
            ld_hi_prev <= rq.ld_hi;
            ld_lo_prev <= rq.ld_lo;
            if (!run_state)             warm <= '0;
            else if (warm != WARM_DONE) warm <= warm + 1'b1;
            if (ld_any) begin
                if (load_hi) cnt[CNT_W-1:WORD_W] <= preset_hi;
                if (load_lo) cnt[WORD_W-1:0]     <= preset_lo;
            end else if (counting) begin
                cnt <= cnt_step;
            end
        end
    end

    AST_HOLD_STOPPED: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (!run_state && !ld_any) |=> $stable(cnt)); // R9

    AST_WARMUP_IDLE: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (run_state && warm != WARM_DONE && !ld_any) |=> $stable(cnt)); // R5

    AST_PLAIN_STEP: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (counting && !ld_any && !frac_full) |=> (cnt == $past(cnt) + ONE)); // R5

    AST_TRIM_OFF_WRAP: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (counting && !ld_any && frac_full && !rq.trim.trim_en) |=> (cnt == $past(cnt) + ONE)); // R10

endmodule

// File: rtl/bkp_rtc.sv
module bkp_rtc
    import bkp_rtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk,
    input  logic              slow_rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);

    logic              run_req;
    trim_cfg_t         trim_cfg;
    logic [HI_W-1:0]   preset_hi;
    logic [WORD_W-1:0] preset_lo;
    logic              ld_hi_tog;
    logic              ld_lo_tog;
    xreq_t             req_bus;
    logic [CNT_W-1:0]  cnt_slow;
    logic              run_slow;
    logic              run_rb;
    logic [CNT_W-1:0]  cnt_bus;

    assign req_bus.run   = run_req;
    assign req_bus.trim  = trim_cfg;
    assign req_bus.ld_hi = ld_hi_tog;
    assign req_bus.ld_lo = ld_lo_tog;

    bkp_rtc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .run_rb    (run_rb),
        .cnt_bus   (cnt_bus),
        .run_req   (run_req),
        .trim_cfg  (trim_cfg),
        .preset_hi (preset_hi),
        .preset_lo (preset_lo),
        .ld_hi_tog (ld_hi_tog),
        .ld_lo_tog (ld_lo_tog)
    );

    bkp_rtc_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
        .slow_clk  (slow_clk),
        .slow_rst  (slow_rst),
        .req_async (req_bus),
        .preset_hi (preset_hi),
        .preset_lo (preset_lo),
        .cnt       (cnt_slow),
        .run_state (run_slow)
    );

    bkp_rtc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_run_back (
        .clk (clk),
        .rst (rst),
        .d   (run_slow),
        .q   (run_rb)
    );

    bkp_rtc_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_back (
        .clk (clk),
        .rst (rst),
        .d   (cnt_slow),
        .q   (cnt_bus)
    );

endmodule

// File: tb/bkp_rtc_test.sv
module bkp_rtc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_clk = 1'b0;
    logic        slow_rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    bkp_rtc uut (
        .clk       (clk),
        .rst       (rst),
        .slow_clk  (slow_clk),
        .slow_rst  (slow_rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [46:0] preset;
        logic        ce;
        logic [4:0]  cal;
        logic [7:0]  k;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{47'h0,              1'b0, 5'd0,     8'd2},
        '{47'h0001_1234_5678, 1'b0, 5'd0,     8'd10},
        '{47'h0000_0003_FFFC, 1'b1, 5'd3,     8'd2},
        '{47'h0000_0003_FFFC, 1'b1, 5'b11100, 8'd2},
        '{47'h0000_0003_FFFC, 1'b0, 5'd3,     8'd2},
        '{47'h7FFF_FFFF_FFFE, 1'b0, 5'd0,     8'd0},
        '{47'h0012_FFFF_FFFE, 1'b0, 5'd0,     8'd1}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R5";
            1: return "R6";
            2, 3, 4: return "R10";
            5: return "R11";
            default: return "R6";
        endcase
    endfunction

    // expected count after n counting edges (R5, R10, R11)
    function automatic logic [46:0] advance(input logic [46:0] v, input logic ce,
                                            input logic [4:0] cv, input int n);
        logic [46:0] r = v;
        for (int i = 0; i < n; i++) begin
            logic [46:0] nx;
            nx = r + 47'd1;
            if (ce && r[14:0] == 15'h7FFF) nx = nx + {{42{cv[4]}}, cv};
            r = nx;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_clk = 1'b1;
            repeat (2) @(negedge clk);
            slow_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic read_cnt(output logic [63:0] v);
        logic [31:0] h, l;
        bus_read(8'h50, h);
        bus_read(8'h54, l);
        v = {h, l};
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [63:0] c, c2;
        logic [46:0] base;
        logic [31:0] cw;

        repeat (3) @(negedge clk);
        tick(2);
        rst = 1'b0; slow_rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        bus_read(8'h38, d); check("R1 ctrl", {32'd0, d}, 64'd0);
        read_cnt(c);        check("R1 count", c, 64'd0);
        // R3 unmapped offsets
        bus_read(8'h3C, d); check("R3 unmapped 0x3C", {32'd0, d}, 64'd0);
        bus_read(8'h00, d); check("R3 unmapped 0x00", {32'd0, d}, 64'd0);

        // R2 field layout
        bus_write(8'h38, 32'h0000_5500);
        bus_read(8'h38, d); check("R2 trim fields", {32'd0, d}, 64'h5500);
        bus_write(8'h38, 32'hFFFF_FFFE);
        bus_read(8'h38, d); check("R2 other bits zero", {32'd0, d}, 64'h7D00);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            cw = (32'(VECS[i].cal) << 10) | (32'(VECS[i].ce) << 8);
            bus_write(8'h38, cw);
            bus_write(8'h50, {17'd0, VECS[i].preset[46:32]});
            bus_write(8'h54, VECS[i].preset[31:0]);
            tick(3);
            read_cnt(c);
            check("R7 load while stopped", c, {17'd0, VECS[i].preset});
            bus_write(8'h38, cw | 32'd1);
            tick(5 + int'(VECS[i].k));
            bus_write(8'h38, cw);
            tick(3);
            bus_read(8'h38, d);
            check("R9 run readback cleared", {63'd0, d[0]}, 64'd0);
            read_cnt(c);
            check(vec_tag(i), c,
                  {17'd0, advance(VECS[i].preset, VECS[i].ce, VECS[i].cal, int'(VECS[i].k) + 3)});
            tick(2);
            read_cnt(c2);
            check("R9 holds after stop", c2, c);
        end

        // R4 enable latency, R8 ignored writes while running
        read_cnt(c);
        base = c[46:0];
        bus_write(8'h38, 32'd1);
        bus_read(8'h38, d); check("R4 readback before slow edges", {63'd0, d[0]}, 64'd0);
        tick(2);
        bus_read(8'h38, d); check("R4 readback after two edges", {63'd0, d[0]}, 64'd0);
        tick(1);
        bus_read(8'h38, d); check("R4 readback after third edge", {63'd0, d[0]}, 64'd1);
        tick(2);
        read_cnt(c); check("R5 idle edges", c, {17'd0, base});
        bus_write(8'h50, 32'h0000_1234);
        bus_write(8'h54, 32'hDEAD_BEEF);
        tick(4);
        read_cnt(c); check("R8 running write ignored", c, {17'd0, advance(base, 1'b0, 5'd0, 4)});
        bus_write(8'h38, 32'd0);
        tick(2);
        bus_read(8'h38, d); check("R4 clear not yet visible", {63'd0, d[0]}, 64'd1);
        tick(1);
        bus_read(8'h38, d); check("R4 clear visible", {63'd0, d[0]}, 64'd0);
        read_cnt(c); check("R9 counts through third edge", c, {17'd0, advance(base, 1'b0, 5'd0, 7)});
        tick(3);
        read_cnt(c2); check("R8 no late load", c2, c);

        finish_run();
    end

endmodule